// File: doc/BRIEF.md
# Fast GPIO Port with Atomic Bit Clear

This block is a 16-pin general-purpose I/O port that a processor reaches over a simple 16-bit register bus with single-cycle access. Each pin can be taken away from the chip's slower peripheral-bus GPIO logic and handed to this port. Once a pin is taken over, the port's direction and data registers decide whether the pin is driven and to what level. A pin that is not taken over keeps the slow path's output value and output enable unchanged.

Software changes outputs either by writing the whole data word or by writing a clear mask. In the clear mask, every 0 bit forces the matching data bit low and every 1 bit leaves it as it is. This lets one bus write drop chosen pins without a read-modify-write sequence that could race with other code. Reading the data word returns, for each taken-over input pin, the pin level after a two-stage synchronizer. For every other pin it returns the stored output value. The clear address is write-only. A read there returns the same data word view.

Top module: `fast_gpio_port`

## Requirements
- R1: A synchronous active-high reset clears the direction, data and pin-enable registers to 0. After reset no pin is driven by the port, and `pin_out`/`pin_oe` equal `slow_out`/`slow_oe`.
- R2: The direction register is at byte offset 0x0 and can be read and written. A direction bit of 1 marks the pin as an output.
- R3: The data register is at byte offset 0x2. A write there stores `bus_wdata`. A read returns the stored bit for every pin that is not a taken-over input.
- R4: The pin-enable register is at byte offset 0x4 and can be read and written. An enable bit of 1 hands the pin to this port.
- R5: A write to byte offset 0x6 clears every data bit whose mask bit is 0 and leaves every data bit whose mask bit is 1 unchanged, in the cycle after the write.
- R6: A write to offset 0x6 never changes the direction or enable registers. A read at offset 0x6 returns the same value as a read at offset 0x2.
- R7: A pin with enable=1 and direction=1 has `pin_oe`=1 and `pin_out` equal to its data bit.
- R8: A pin with enable=0 or direction=0 has `pin_out`=`slow_out` and `pin_oe`=`slow_oe` for that bit.
- R9: For a pin with enable=1 and direction=0, the data read returns the `pin_in` level that was sampled at the clock edge two edges earlier. A level applied before clock edge k is visible after edge k+1.
- R10: A write to any address other than 0x0, 0x2, 0x4 or 0x6 (including odd addresses) changes no register. A read from such an address returns 0. `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 16 | Write data or clear mask |
| bus_rdata | output | 16 | Read data, combinational in the access cycle |
| pin_in | input | 16 | Pad input levels, asynchronous |
| slow_out | input | 16 | Output values from the slow GPIO path |
| slow_oe | input | 16 | Output enables from the slow GPIO path |
| pin_out | output | 16 | Value driven toward each pad |
| pin_oe | output | 16 | Output enable toward each pad |

## Verification
A corrupted enable or direction bit shows up in the same cycle on `pin_oe` and `pin_out`: a pin either breaks away from the slow-path values or is left on them when it should not be. It also shows in the mixed data read view. A wrong data bit is visible at once on any owned output pin, and on the next read of offset 0x2 or 0x6. A synchronizer with the wrong depth moves an input change one edge early or late, and the per-cycle reference comparison catches that within the two-edge window. A bad clear-mask polarity appears one cycle after the clear write, both on the owned pins and in the read data.

// File: rtl/fgp_pkg.sv
package fgp_pkg;

    localparam int PIN_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [31:0] OFF_DIR  = 32'h0;
    localparam logic [31:0] OFF_DATA = 32'h2;
    localparam logic [31:0] OFF_EN   = 32'h4;
    localparam logic [31:0] OFF_CLR  = 32'h6;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_DATA = 2'd1,
        REG_EN   = 2'd2,
        REG_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } dec_t;

    typedef struct packed {
        logic dir;
        logic data;
        logic en;
        logic clr;
    } wr_strobe_t;

    function automatic dec_t decode_addr(input logic [31:0] a);
        dec_t d;
        d.hit = 1'b1;
        d.sel = REG_DIR;
        case (a)
            OFF_DIR:  d.sel = REG_DIR;
            OFF_DATA: d.sel = REG_DATA;
            OFF_EN:   d.sel = REG_EN;
            OFF_CLR:  d.sel = REG_CLR;
            default:  d.hit = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fgp_sync.sv
module fgp_sync #(
    parameter int PIN_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] async_in,
    output logic [PIN_W-1:0] sync_out
);
    logic [PIN_W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/fgp_regfile.sv
module fgp_regfile
    import fgp_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    input  logic [PIN_W-1:0]  sync_in,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic [PIN_W-1:0]  dir_q,
    output logic [PIN_W-1:0]  data_q,
    output logic [PIN_W-1:0]  en_q
);
    dec_t             dec;
    wr_strobe_t       wr;
    logic [PIN_W-1:0] in_mask;
    logic [PIN_W-1:0] data_view;
    logic [PIN_W-1:0] data_nxt;

    always_comb dec = decode_addr(32'(bus_addr));

    always_comb begin
        wr = '0;
        if (bus_sel && bus_wr && dec.hit) begin
            case (dec.sel)
                REG_DIR:  wr.dir  = 1'b1;
                REG_DATA: wr.data = 1'b1;
                REG_EN:   wr.en   = 1'b1;
                REG_CLR:  wr.clr  = 1'b1;
                default:  wr      = '0;
            endcase
        end
    end

    // one write source per data bit per cycle
    always_comb begin
        if (wr.data)     data_nxt = bus_wdata;
        else if (wr.clr) data_nxt = data_q & bus_wdata;
        else             data_nxt = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            en_q   <= '0;
            data_q <= '0;
        end else begin
            if (wr.dir) dir_q <= bus_wdata;
            if (wr.en)  en_q  <= bus_wdata;
            data_q <= data_nxt;
        end
    end

    assign in_mask   = en_q & ~dir_q;
    assign data_view = (data_q & ~in_mask) | (sync_in & in_mask);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && dec.hit) begin
            case (dec.sel)
                REG_DIR:  bus_rdata = dir_q;
                REG_DATA: bus_rdata = data_view;
                REG_EN:   bus_rdata = en_q;
                REG_CLR:  bus_rdata = data_view;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fgp_pinmux.sv
module fgp_pinmux #(
    parameter int PIN_W = 16
) (
    input  logic [PIN_W-1:0] en_q,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] data_q,
    input  logic [PIN_W-1:0] slow_out,
    input  logic [PIN_W-1:0] slow_oe,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        logic owned;
        assign owned      = en_q[p] & dir_q[p];
        assign pin_out[p] = owned ? data_q[p] : slow_out[p];
        assign pin_oe[p]  = owned ? 1'b1      : slow_oe[p];
    end
endmodule

// File: rtl/fast_gpio_port.sv
module fast_gpio_port #(
    parameter int PIN_W  = fgp_pkg::PIN_W,
    parameter int ADDR_W = fgp_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic [PIN_W-1:0]  slow_out,
    input  logic [PIN_W-1:0]  slow_oe,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] data_q;
    logic [PIN_W-1:0] en_q;
    logic [PIN_W-1:0] pin_sync;

    fgp_sync #(.PIN_W(PIN_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    fgp_regfile #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sync_in   (pin_sync),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .en_q      (en_q)
    );

    fgp_pinmux #(.PIN_W(PIN_W)) u_mux (
        .en_q     (en_q),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .slow_out (slow_out),
        .slow_oe  (slow_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );
endmodule

// File: rtl/fast_gpio_port_chk.sv
module fast_gpio_port_chk #(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pin_oe,
    input logic [PIN_W-1:0]  dir_q,
    input logic [PIN_W-1:0]  data_q,
    input logic [PIN_W-1:0]  en_q
);
    logic mapped;
    logic clr_wr;
    assign mapped = (32'(bus_addr) == fgp_pkg::OFF_DIR)  || (32'(bus_addr) == fgp_pkg::OFF_DATA) ||
                    (32'(bus_addr) == fgp_pkg::OFF_EN)   || (32'(bus_addr) == fgp_pkg::OFF_CLR);
    assign clr_wr = bus_sel && bus_wr && (32'(bus_addr) == fgp_pkg::OFF_CLR);

    AST_CLEAR_ONLY_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> data_q == ($past(data_q) & $past(bus_wdata))); // R5

    AST_CLEAR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ($stable(en_q) && $stable(dir_q))); // R6

    AST_OWNED_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        ((en_q & dir_q & ~pin_oe) == '0)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !mapped) |-> bus_rdata == '0); // R10

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && mapped) |=> ($stable(data_q) && $stable(en_q) && $stable(dir_q))); // R10
endmodule

bind fast_gpio_port fast_gpio_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .en_q      (en_q)
);

// File: tb/fast_gpio_port_test.sv
`timescale 1ns/1ps
module fast_gpio_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] slow_out = '0;
    logic [15:0] slow_oe = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [15:0] m_dir, m_data, m_en;
    logic [15:0] hist[$];

    always #2.5 clk = ~clk;

    fast_gpio_port uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .slow_out(slow_out), .slow_oe(slow_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] synced();
        return (hist.size() > 1) ? hist[1] : 16'h0;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        logic [15:0] inp;
        inp = m_en & ~m_dir;
        case (a)
            4'h0: return m_dir;
            4'h2, 4'h6: return (m_data & ~inp) | (synced() & inp);
            4'h4: return m_en;
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir = '0; m_data = '0; m_en = '0;
            hist.delete();
            hist.push_front(16'h0);
            hist.push_front(16'h0);
        end else begin
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'h0: m_dir = bus_wdata;
                    4'h2: m_data = bus_wdata;
                    4'h4: m_en = bus_wdata;
                    4'h6: m_data = m_data & bus_wdata;
                    default: ;
                endcase
            end
            hist.push_front(pin_in);
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (chk_on && !done) begin
            logic [15:0] own;
            string rq;
            own = m_en & m_dir;
            case (bus_addr)
                4'h0: rq = "R2";
                4'h2: rq = "R3/R9";
                4'h4: rq = "R4";
                4'h6: rq = "R6";
                default: rq = "R10";
            endcase
            check(rq, "rdata", bus_rdata,
                  (bus_sel && !bus_wr) ? exp_read(bus_addr) : 16'h0);
            check("R7/R8", "pin_out", pin_out, (m_data & own) | (slow_out & ~own));
            check("R7/R8", "pin_oe", pin_oe, own | (slow_oe & ~own));
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, "read", bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        slow_out = 16'h3C5A; slow_oe = 16'hF00F;
        // R1: reset state
        rd(4'h0, 16'h0000, "R1");
        rd(4'h2, 16'h0000, "R1");
        rd(4'h4, 16'h0000, "R1");
        #0.5;
        check("R1", "pin_out", pin_out, 16'h3C5A);
        check("R1", "pin_oe", pin_oe, 16'hF00F);
        // R2, R3, R4
        wr(4'h0, 16'h00FF);
        rd(4'h0, 16'h00FF, "R2");
        wr(4'h2, 16'hA5C3);
        rd(4'h2, 16'hA5C3, "R3");
        wr(4'h4, 16'h0F0F);
        rd(4'h4, 16'h0F0F, "R4");
        idle();
        #1;
        // R7: owned pins 3:0; R8: the rest follow the slow path
        check("R7", "pin_oe", pin_oe & 16'h000F, 16'h000F);
        check("R7", "pin_out", pin_out & 16'h000F, 16'h0003);
        check("R8", "pin_out", pin_out & 16'hFFF0, 16'h3C50);
        check("R8", "pin_oe", pin_oe & 16'hFFF0, 16'hF000);
        // R9: enabled inputs are pins 11:8, two-edge latency
        @(negedge clk);
        pin_in = 16'h0A00;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h2;
        #1; check("R9", "sync before edge", bus_rdata, 16'hA0C3);
        @(negedge clk); #1; check("R9", "sync after 1 edge", bus_rdata, 16'hA0C3);
        @(negedge clk); #1; check("R9", "sync after 2 edges", bus_rdata, 16'hAAC3);
        // R5, R6: active-low clear mask
        wr(4'h6, 16'hFF0F);
        rd(4'h6, 16'hAA03, "R6");
        rd(4'h2, 16'hAA03, "R5");
        rd(4'h0, 16'h00FF, "R6");
        rd(4'h4, 16'h0F0F, "R6");
        wr(4'h6, 16'hFFFF);
        rd(4'h2, 16'hAA03, "R5");
        wr(4'h6, 16'hFFFE);
        rd(4'h2, 16'hAA02, "R5");
        // R10: unmapped and odd offsets
        wr(4'h8, 16'h1234);
        wr(4'h3, 16'h0000);
        wr(4'hE, 16'hFFFF);
        rd(4'h0, 16'h00FF, "R10");
        rd(4'h2, 16'hAA02, "R10");
        rd(4'h4, 16'h0F0F, "R10");
        rd(4'h8, 16'h0000, "R10");
        rd(4'h5, 16'h0000, "R10");
        // mixed random traffic, checked each cycle against the reference
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bus_sel   = ($urandom % 4) != 0;
            bus_wr    = $urandom % 2;
            bus_addr  = 4'($urandom % 10);
            bus_wdata = 16'($urandom);
            pin_in    = 16'($urandom);
            slow_out  = 16'($urandom);
            slow_oe   = 16'($urandom);
        end
        idle();
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule